// File: doc/BRIEF.md
# Multi-channel lead-in PWM generator

A bank of independent pulse-width-modulated outputs that share one clock. Software sets up each channel through two 32-bit registers. The control register carries an enable flag, a lead-in interval and a period limit. The timing register carries a high-phase count and a low-phase count. All values are in clock cycles, and software converts from time units before it writes them.

When a channel is enabled, the output stays low for the lead-in interval. It then runs periods made of a high phase followed by a low phase, either without end or until a programmed number of periods has completed. Timing written while a channel runs is held as a shadow copy and takes effect at the next period boundary. Clearing the enable flag stops the output at once.

The register port uses a one-cycle write strobe and a shared byte address. It returns registered read data.

Top module: `pwm_bank`

## Requirements
- R1: For channel n (0..5), the control register is at byte address 4*n and the timing register at byte address 0x20 + 4*n. A read returns the last value written, on `rdata_o`, one clock edge after the address is presented.
- R2: A write to any other address, including an address that is not a multiple of 4, changes no register and starts no channel. A read of such an address returns zero.
- R3: After reset, every register reads zero and every output is low.
- R4: In the control register, bit 31 enables the channel, bits 30:16 hold the lead-in count and bits 15:0 hold the period limit. The output is first affected in the cycle after the second rising edge that follows the enabling write. It is then held low for the lead-in count of cycles, and the first high phase follows directly.
- R5: In the timing register, bits 31:16 hold the high count H and bits 15:0 the low count L. Each period drives high for H cycles and then low for L cycles, with no gap between periods.
- R6: A nonzero period limit N stops the channel after N periods, and the output then stays low while the enable bit still reads back as 1. A limit of zero means the periods never end.
- R7: H=0 gives a constant low output. L=0 with H>0 gives a constant high output. H=L=0 keeps the output low.
- R8: A timing write while a channel runs does not alter the period in progress. The next period uses the new values.
- R9: Writing the control register with bit 31 clear drives the output low in the cycle right after that write edge, abandoning the period in progress.
- R10: Channels run independently, and a channel that is not enabled keeps its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | ADDR_W | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The bench targets the lead-in edge. A counter off by one there shifts every later high phase by a cycle, which shows up in the per-cycle waveform compare. It also checks that a channel which has reached its period limit goes quiet while still reading as enabled; a design that cleared the enable flag, or that never stopped, fails the waveform check or the readback. A timing write in the middle of a period must leave the current period untouched, so a design that loaded the values at once would cut the first period short. The bench also probes zero-count timing, an immediate disable during a high phase, and writes to the gap and to misaligned addresses, which must neither start a channel nor read back.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W    = 16;
  localparam int LEAD_W   = 15;
  localparam int TIM_WORD = 8;  // timing bank starts at word 8 (byte 0x20)

  typedef struct packed {
    logic              en;
    logic [LEAD_W-1:0] lead;
    logic [CNT_W-1:0]  rep;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } timing_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o [NUM_CH],
  output timing_t           tim_o  [NUM_CH]
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [NUM_CH-1:0] hit_ctrl, hit_tim;
  ctrl_t             ctrl_q [NUM_CH];
  timing_t           tim_q  [NUM_CH];
  logic [31:0]       rd_d;

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_reg
    assign hit_ctrl[n] = aligned && (widx == WIDX_W'(n));
    assign hit_tim[n]  = aligned && (widx == WIDX_W'(TIM_WORD + n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[n] <= '0;
        tim_q[n]  <= '0;
      end else if (wr_en_i) begin
        if (hit_ctrl[n]) ctrl_q[n] <= ctrl_t'(wdata_i);
        if (hit_tim[n])  tim_q[n]  <= timing_t'(wdata_i);
      end
    end

    assign ctrl_o[n] = ctrl_q[n];
    assign tim_o[n]  = tim_q[n];
  end

  always_comb begin
    rd_d = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit_ctrl[n]) rd_d = ctrl_q[n];
      if (hit_tim[n])  rd_d = tim_q[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ctrl_t   ctrl_i,
  input  timing_t tim_i,
  output logic    pwm_o
);
  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_DONE} st_e;

  st_e              state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  timing_t          act_q, act_d;
  logic             begin_per, end_per;
  timing_t          bp_val;
  logic [CNT_W:0]   per_next;

  assign per_next = (CNT_W+1)'(per_q) + (CNT_W+1)'(1);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    per_d     = per_q;
    act_d     = act_q;
    begin_per = 1'b0;
    end_per   = 1'b0;
    bp_val    = act_q;

    unique case (state_q)
      ST_IDLE: begin
        act_d = tim_i;
        per_d = '0;
        if (ctrl_i.lead != '0) begin
          state_d = ST_LEAD;
          cnt_d   = CNT_W'(ctrl_i.lead) - CNT_W'(1);
        end else begin
          begin_per = 1'b1;
          bp_val    = tim_i;
        end
      end
      ST_LEAD: begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else             begin_per = 1'b1;
      end
      ST_HIGH: begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else if (act_q.lo != '0) begin
          state_d = ST_LOW;
          cnt_d   = act_q.lo - CNT_W'(1);
        end else end_per = 1'b1;
      end
      ST_LOW: begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else             end_per = 1'b1;
      end
      default: ;  // ST_DONE holds
    endcase

    if (end_per) begin
      if (ctrl_i.rep != '0 && per_next >= (CNT_W+1)'(ctrl_i.rep)) begin
        state_d = ST_DONE;
      end else begin
        if (ctrl_i.rep != '0) per_d = per_next[CNT_W-1:0];
        act_d     = tim_i;  // shadow takes effect at the boundary
        bp_val    = tim_i;
        begin_per = 1'b1;
      end
    end

    if (begin_per) begin
      if (bp_val.hi != '0) begin
        state_d = ST_HIGH;
        cnt_d   = bp_val.hi - CNT_W'(1);
      end else begin
        state_d = ST_LOW;
        cnt_d   = (bp_val.lo == '0) ? '0 : bp_val.lo - CNT_W'(1);
      end
    end

    if (!ctrl_i.en) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      act_q   <= act_d;
    end
  end

  assign pwm_o = ctrl_i.en && (state_q == ST_HIGH);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  ctrl_t             ctrl [NUM_CH];
  timing_t           tim  [NUM_CH];
  logic [NUM_CH-1:0] ch_en;

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl),
    .tim_o   (tim)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign ch_en[n] = ctrl[n].en;
    pwm_bank_chan chan_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl[n]),
      .tim_i  (tim[n]),
      .pwm_o  (pwm_o[n])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] ch_en
);
  logic [ADDR_W-3:0] w;
  logic              mapped;
  assign w      = addr_i[ADDR_W-1:2];
  assign mapped = (addr_i[1:0] == 2'b00) &&
                  ((int'(w) < NUM_CH) || (int'(w) >= 8 && int'(w) < 8 + NUM_CH));

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |=> rdata_o == '0); // R2

  AST_OUT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~ch_en) == '0); // R10

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ast
    AST_DISABLE_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && addr_i == ADDR_W'(4 * n) && !wdata_i[31] |=> !pwm_o[n]); // R9

    AST_START_NEEDS_PRIOR_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en[n] |=> !pwm_o[n]); // R4
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pwm_o   (pwm_o),
  .ch_en   (ch_en)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
  localparam int NUM_CH = 6;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] pwm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  typedef struct packed {
    int ch; int lead; int rep; int hi; int lo; int ncyc;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{ch: 0, lead: 0, rep: 0, hi: 3, lo: 2, ncyc: 20},  // R5 plain
    '{ch: 2, lead: 3, rep: 2, hi: 2, lo: 2, ncyc: 18},  // R4 R6 lead + limit
    '{ch: 5, lead: 0, rep: 0, hi: 0, lo: 3, ncyc: 12},  // R7 high zero
    '{ch: 3, lead: 1, rep: 0, hi: 4, lo: 0, ncyc: 14},  // R7 low zero
    '{ch: 4, lead: 0, rep: 3, hi: 0, lo: 0, ncyc: 8},   // R7 both zero
    '{ch: 1, lead: 2, rep: 1, hi: 1, lo: 1, ncyc: 10}   // R6 single period
  };

  function automatic logic exp_bit(int k, int lead, int rep, int h, int l);
    int p, j;
    p = (h + l == 0) ? 1 : h + l;
    if (k < lead) return 1'b0;
    j = k - lead;
    if (rep != 0 && (j / p) >= rep) return 1'b0;
    return (j % p) < h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  function automatic logic [31:0] ctrl_word(int en, int lead, int rep);
    return {en[0], lead[14:0], rep[15:0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    logic [NUM_CH-1:0] ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    @(negedge clk);
    chk("R3 pwm after reset", 32'(pwm), 32'h0);
    rd(8'h00, r); chk("R3 ctrl0 reset", r, 32'h0);
    rd(8'h34, r); chk("R3 tim5 reset", r, 32'h0);

    // R1 readback of both banks
    wr(8'h28, 32'h1234_5678);
    rd(8'h28, r); chk("R1 tim2 readback", r, 32'h1234_5678);
    wr(8'h14, 32'h0001_0009);
    rd(8'h14, r); chk("R1 ctrl5 readback", r, 32'h0001_0009);
    wr(8'h14, 32'h0);

    // R2 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, r); chk("R2 gap read", r, 32'h0);
    wr(8'h01, 32'h8000_0000);
    rd(8'h01, r); chk("R2 misaligned read", r, 32'h0);
    rd(8'h00, r); chk("R2 ctrl0 untouched", r, 32'h0);
    repeat (4) @(negedge clk);
    chk("R2 no channel started", 32'(pwm), 32'h0);

    // Table walk: R4 R5 R6 R7 R10
    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      wr(8'(32'h20 + 4 * v.ch), {v.hi[15:0], v.lo[15:0]});
      wr(8'(4 * v.ch), ctrl_word(1, v.lead, v.rep));
      for (int k = 0; k < v.ncyc; k++) begin
        @(negedge clk);
        ex = '0;
        ex[v.ch] = exp_bit(k, v.lead, v.rep, v.hi, v.lo);
        chk($sformatf("R5 R10 vec%0d cyc%0d", i, k), 32'(pwm), 32'(ex));
      end
      rd(8'(4 * v.ch), r);
      chk($sformatf("R6 vec%0d enable kept", i), r, ctrl_word(1, v.lead, v.rep));
      wr(8'(4 * v.ch), 32'h0);
      @(negedge clk);
      chk($sformatf("R10 vec%0d idle", i), 32'(pwm), 32'h0);
    end

    // R8 timing update mid-period
    wr(8'h24, {16'd4, 16'd4});
    wr(8'h04, ctrl_word(1, 0, 0));
    for (int k = 0; k < 20; k++) begin
      logic e;
      @(negedge clk);
      if (k == 2) wr_en = 1'b0;
      e = (k < 8) ? (k < 4) : (((k - 8) % 3) < 2);
      chk($sformatf("R8 cyc%0d", k), 32'(pwm[1]), 32'(e));
      if (k == 1) begin
        wr_en = 1'b1; addr = 8'h24; wdata = {16'd2, 16'd1};
      end
    end
    wr(8'h04, 32'h0);

    // R9 disable during high phase
    wr(8'h20, {16'd5, 16'd5});
    wr(8'h00, ctrl_word(1, 0, 0));
    @(negedge clk);
    @(negedge clk);
    chk("R9 high before disable", 32'(pwm[0]), 32'h1);
    wr_en = 1'b1; addr = 8'h00; wdata = 32'h0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 low right after write", 32'(pwm[0]), 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 stays low", 32'(pwm), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule